// File: doc/BRIEF.md
# Masked Interrupt and Wake Controller

This block collects three interrupt requests for a small processor core: an active-low timer overflow line, a change on a general-purpose input port, and an active-low external interrupt pin. Each request sets its own bit in a pending-flag register. Software reads the flags through a mask and can clear them by writing. A global enable bit gates the request to the core. Taking an interrupt turns that enable off.

A small state machine has three states: `ST_RUN`, `ST_SLEEP` and `ST_WAKE`. Its transitions are:

- **enter-sleep**: from `ST_RUN` to `ST_SLEEP` on `sleep_req`. The global enable is recorded at this point.
- **wake-on-pending**: from `ST_SLEEP` to `ST_WAKE` when any flag is both set and unmasked.
- **resume**: from `ST_WAKE` back to `ST_RUN` after one cycle.

In `ST_WAKE` the block pulses `wake`. It also states through `resume_vec` whether the core jumps to the interrupt vector at address 0x008 or continues at the instruction after the sleep instruction.

The port-change source compares the port pins with a reference word. That reference is loaded whenever the core reads the port. Software must therefore read the port before it unmasks the change source.

Top module: `imc_ctrl`

## Requirements
- R1: Bit 0 of the flags is set by a falling edge on `tmr_ovf_n`. Bit 2 is set by a falling edge on `ext_int_n`. Bit 1 is set when `port_in` starts to differ from the stored reference. In each case the flag becomes visible in the cycle after the edge is present at the inputs.
- R2: `rd_flags` always equals the flag register ANDed bit by bit with the mask register, using the same bit positions.
- R3: On `flag_wr` each flag bit becomes its old value ANDed with the matching `wr_data` bit. A written 1 never sets a flag.
- R4: If a source sets a flag bit in the same cycle that a write clears it, the bit ends up set.
- R5: `port_rd` loads `port_in` into the reference. While the port equals the reference, no port-change flag is raised. After reset the reference is zero, and a mismatch already present when reset is released raises no flag.
- R6: `mask_wr` loads `wr_data` into the mask. A flag whose mask bit is 0 neither raises `irq` nor ends sleep.
- R7: `irq` is high only in `ST_RUN`, and only when the global enable is set and an unmasked flag is pending.
  - `gie_set` sets the enable.
  - `gie_clr` or `irq_ack` clears it.
  - A clear wins over a set in the same cycle.
- R8: `sleep_req` in `ST_RUN` makes `asleep` high from the next cycle and records the global enable.
- R9: In `ST_SLEEP`, any pending unmasked flag causes the next cycle to be `ST_WAKE`. In that cycle `wake` is high for exactly one cycle and `asleep` is low.
- R10: During `wake`, `resume_vec` is 1 if the enable was set at sleep entry, meaning a jump to vector 0x008. It is 0 otherwise, meaning execution continues after the sleep instruction.
- R11: After reset the flags, the mask and the enable are zero, the state is `ST_RUN`, and `rd_flags`, `irq`, `wake`, `asleep` and `resume_vec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf_n | input | 1 | Timer overflow request, active on its falling edge |
| ext_int_n | input | 1 | External interrupt pin, active on its falling edge |
| port_in | input | PORT_W | Input port pins watched for change |
| port_rd | input | 1 | Port read strobe; loads the change reference |
| flag_wr | input | 1 | Flag register write strobe (clear only) |
| mask_wr | input | 1 | Mask register write strobe |
| wr_data | input | 3 | Write data for flags or mask (bit 0 timer, bit 1 port, bit 2 external) |
| gie_set | input | 1 | Global enable set strobe |
| gie_clr | input | 1 | Global enable clear strobe |
| irq_ack | input | 1 | Core takes the interrupt; clears global enable |
| sleep_req | input | 1 | Core executes the sleep instruction |
| rd_flags | output | 3 | Flags ANDed with the mask |
| irq | output | 1 | Interrupt request to the core |
| resume_vec | output | 1 | With `wake`: 1 = vector 0x008, 0 = next instruction |
| wake | output | 1 | One-cycle wake pulse |
| asleep | output | 1 | High while in `ST_SLEEP` |

## Verification
The bench builds the block with `PORT_W = 4`. With that width, random port values often match the stored reference and often differ from it. As a result, both the quiet case and the change case of the port source occur many times in a short run. It also makes it likely that a port change lands in the same cycle as a flag write or a sleep entry. The default `PORT_W = 8` uses the same logic with a wider compare.

// File: rtl/imc_pkg.sv
package imc_pkg;
    localparam int NSRC     = 3;
    localparam int SRC_TMR  = 0;
    localparam int SRC_PORT = 1;
    localparam int SRC_EXT  = 2;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wake_st_t;
endpackage

// File: rtl/imc_edge_det.sv
// Falling-edge detector; the history register resets low so no edge is
// reported in the first cycle after reset.
module imc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign fall = prev_q & ~level;
endmodule

// File: rtl/imc_port_watch.sv
// Holds the reference word captured on a port read and reports mismatch.
module imc_port_watch #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    output logic              differ
);
    logic [PORT_W-1:0] ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ref_q <= '0;
        else if (port_rd) ref_q <= port_in;
    end

    assign differ = (port_in != ref_q);
endmodule

// File: rtl/imc_flag_reg.sv
// Pending flags (clear-only from software, set wins) and the mask.
module imc_flag_reg #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic            flag_wr,
    input  logic            mask_wr,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] flag_q,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] flag_d;

    always_comb begin
        for (int b = 0; b < NSRC; b++) begin
            flag_d[b] = set_vec[b] | (flag_q[b] & (~flag_wr | wr_data[b]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (mask_wr) mask_q <= wr_data;
        end
    end

    assign pend = flag_q & mask_q;
endmodule

// File: rtl/imc_wake_fsm.sv
// Global enable plus run / sleep / wake sequencing.
module imc_wake_fsm
    import imc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic irq_ack,
    input  logic sleep_req,
    output logic irq,
    output logic wake,
    output logic asleep,
    output logic resume_vec
);
    wake_st_t state_q, state_d;
    logic     gie_q;
    logic     gie_at_sleep_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep_req) state_d = ST_SLEEP;
            ST_SLEEP: if (pend_any)  state_d = ST_WAKE;
            ST_WAKE:  state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= ST_RUN;
            gie_q          <= 1'b0;
            gie_at_sleep_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (gie_clr || irq_ack) gie_q <= 1'b0;
            else if (gie_set)       gie_q <= 1'b1;
            if (state_q == ST_RUN && sleep_req) gie_at_sleep_q <= gie_q;
        end
    end

    always_comb begin
        irq        = 1'b0;
        wake       = 1'b0;
        asleep     = 1'b0;
        resume_vec = 1'b0;
        unique case (state_q)
            ST_RUN:   irq = gie_q & pend_any;
            ST_SLEEP: asleep = 1'b1;
            ST_WAKE: begin
                wake       = 1'b1;
                resume_vec = gie_at_sleep_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
    import imc_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_ovf_n,
    input  logic              ext_int_n,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              flag_wr,
    input  logic              mask_wr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic              irq_ack,
    input  logic              sleep_req,
    output logic [NSRC-1:0]   rd_flags,
    output logic              irq,
    output logic              resume_vec,
    output logic              wake,
    output logic              asleep
);
    logic              port_diff;
    logic [NSRC-1:0]   src_lvl;
    logic [NSRC-1:0]   set_vec;
    logic [NSRC-1:0]   flag_q;
    logic [NSRC-1:0]   pend;

    imc_port_watch #(.PORT_W(PORT_W)) port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_in (port_in),
        .port_rd (port_rd),
        .differ  (port_diff)
    );

    // The port source falls when a mismatch begins.
    assign src_lvl[SRC_TMR]  = tmr_ovf_n;
    assign src_lvl[SRC_PORT] = ~port_diff;
    assign src_lvl[SRC_EXT]  = ext_int_n;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        imc_edge_det edge_i (
            .clk   (clk),
            .rst_n (rst_n),
            .level (src_lvl[s]),
            .fall  (set_vec[s])
        );
    end

    imc_flag_reg #(.NSRC(NSRC)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .flag_wr (flag_wr),
        .mask_wr (mask_wr),
        .wr_data (wr_data),
        .flag_q  (flag_q),
        .pend    (pend)
    );

    imc_wake_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (|pend),
        .gie_set    (gie_set),
        .gie_clr    (gie_clr),
        .irq_ack    (irq_ack),
        .sleep_req  (sleep_req),
        .irq        (irq),
        .wake       (wake),
        .asleep     (asleep),
        .resume_vec (resume_vec)
    );

    assign rd_flags = pend;
endmodule

// File: rtl/imc_ctrl_chk.sv
module imc_ctrl_chk #(
    parameter int NSRC = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            irq_ack,
    input logic            gie_clr,
    input logic            wake,
    input logic            asleep,
    input logic            resume_vec,
    input logic            sleep_req,
    input logic            flag_wr,
    input logic [NSRC-1:0] wr_data,
    input logic [NSRC-1:0] set_vec,
    input logic [NSRC-1:0] flag_q
);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq);
    // R7
    gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !irq);
    // R7
    no_irq_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !irq);
    // R8
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !asleep && !wake) |=> asleep);
    // R9
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
    // R9
    wake_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(asleep) && !asleep));
    // R10
    vec_with_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_vec |-> wake);
    // R3
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wr_data == '0 && set_vec == '0) |=> (flag_q == '0));
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && set_vec[0]) |=> flag_q[0]);
endmodule

bind imc_ctrl imc_ctrl_chk #(.NSRC(imc_pkg::NSRC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .gie_clr    (gie_clr),
    .wake       (wake),
    .asleep     (asleep),
    .resume_vec (resume_vec),
    .sleep_req  (sleep_req),
    .flag_wr    (flag_wr),
    .wr_data    (wr_data),
    .set_vec    (set_vec),
    .flag_q     (flag_q)
);

// File: tb/imc_ctrl_tb_top.sv
module imc_ctrl_tb_top;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_n = 1'b1, ext_n = 1'b1;
    logic [PW-1:0] port_in = '0;
    logic          port_rd = 0, flag_wr = 0, mask_wr = 0;
    logic [2:0]    wr_data = '0;
    logic          gie_set = 0, gie_clr = 0, irq_ack = 0, sleep_req = 0;
    logic [2:0]    rd_flags;
    logic          irq, resume_vec, wake, asleep;

    int n_chk = 0;
    int n_fail = 0;
    int unsigned seed_v;
    logic done = 1'b0;

    always #5 clk = ~clk;

    imc_ctrl #(.PORT_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_ovf_n(tmr_n), .ext_int_n(ext_n),
        .port_in(port_in), .port_rd(port_rd), .flag_wr(flag_wr),
        .mask_wr(mask_wr), .wr_data(wr_data), .gie_set(gie_set),
        .gie_clr(gie_clr), .irq_ack(irq_ack), .sleep_req(sleep_req),
        .rd_flags(rd_flags), .irq(irq), .resume_vec(resume_vec),
        .wake(wake), .asleep(asleep)
    );

    // ---------------- reference model built from the requirements ----------
    logic [2:0]    m_flags, m_mask, m_prev, lv;
    logic [PW-1:0] m_ref;
    logic          m_gie, m_atsl;
    int            m_st; // 0 run, 1 sleep, 2 wake

    function automatic logic [2:0] f_flags(input logic [2:0] fl, input logic wr,
                                           input logic [2:0] wd, input logic [2:0] st);
        return (wr ? (fl & wd) : fl) | st;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags <= '0; m_mask <= '0; m_prev <= '0; m_ref <= '0;
            m_gie <= 1'b0; m_atsl <= 1'b0; m_st <= 0;
        end else begin
            lv = {ext_n, (port_in == m_ref), tmr_n};
            m_prev  <= lv;
            m_flags <= f_flags(m_flags, flag_wr, wr_data, m_prev & ~lv);
            if (mask_wr) m_mask <= wr_data;
            if (port_rd) m_ref <= port_in;
            if (gie_clr || irq_ack) m_gie <= 1'b0;
            else if (gie_set)       m_gie <= 1'b1;
            case (m_st)
                0: if (sleep_req) begin m_st <= 1; m_atsl <= m_gie; end
                1: if ((m_flags & m_mask) != 0) m_st <= 2;
                default: m_st <= 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 rd_flags", int'(rd_flags), int'(m_flags & m_mask));
            chk("R7 irq", int'(irq), int'(m_gie && (m_flags & m_mask) != 0 && m_st == 0));
            chk("R8 asleep", int'(asleep), int'(m_st == 1));
            chk("R9 wake", int'(wake), int'(m_st == 2));
            chk("R10 resume_vec", int'(resume_vec), int'(m_st == 2 && m_atsl));
        end
    end

    task automatic tick();
        @(negedge clk);
        port_rd = 0; flag_wr = 0; mask_wr = 0; gie_set = 0; gie_clr = 0;
        irq_ack = 0; sleep_req = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rd_flags", int'(rd_flags), 0);
        chk("R11 irq", int'(irq), 0);
        chk("R11 wake", int'(wake), 0);
        chk("R11 asleep", int'(asleep), 0);
        chk("R11 resume_vec", int'(resume_vec), 0);

        mask_wr = 1; wr_data = 3'b111; tick();
        tmr_n = 0; tick(); tmr_n = 1;
        chk("R1 timer edge", int'(rd_flags), 1);
        ext_n = 0; tick(); ext_n = 1;
        chk("R1 external edge", int'(rd_flags), 5);
        port_in = 4'h3; tick();
        chk("R1 port change", int'(rd_flags), 7);
        flag_wr = 1; wr_data = 3'b111; tick();
        chk("R3 write ones keeps", int'(rd_flags), 7);
        flag_wr = 1; wr_data = 3'b011; tick();
        chk("R3 clear bit2", int'(rd_flags), 3);
        mask_wr = 1; wr_data = 3'b010; tick();
        chk("R2 masked read", int'(rd_flags), 2);
        mask_wr = 1; wr_data = 3'b111; tick();
        chk("R6 mask reload", int'(rd_flags), 3);
        port_rd = 1; tick();
        flag_wr = 1; wr_data = 3'b000; tick();
        tick(); tick();
        chk("R5 equal port no flag", int'(rd_flags), 0);
        flag_wr = 1; wr_data = 3'b000; tmr_n = 0; tick(); tmr_n = 1;
        chk("R4 set beats clear", int'(rd_flags), 1);

        mask_wr = 1; wr_data = 3'b000; tick();
        chk("R6 all masked", int'(rd_flags), 0);
        gie_set = 1; tick();
        chk("R6 masked no irq", int'(irq), 0);
        sleep_req = 1; tick();
        chk("R8 asleep", int'(asleep), 1);
        ext_n = 0; tick(); ext_n = 1;
        tick();
        chk("R6 masked no wake", int'(asleep), 1);
        mask_wr = 1; wr_data = 3'b100; tick();
        chk("R9 still asleep", int'(asleep), 1);
        tick();
        chk("R9 wake pulse", int'(wake), 1);
        chk("R10 vector", int'(resume_vec), 1);
        tick();
        chk("R9 wake one cycle", int'(wake), 0);
        chk("R7 irq after wake", int'(irq), 1);
        irq_ack = 1; tick();
        chk("R7 ack clears", int'(irq), 0);

        flag_wr = 1; wr_data = 3'b000; tick();
        sleep_req = 1; tick();
        ext_n = 0; tick(); ext_n = 1;
        tick();
        chk("R9 wake pulse 2", int'(wake), 1);
        chk("R10 continue", int'(resume_vec), 0);
        tick();
        chk("R7 disabled no irq", int'(irq), 0);
        gie_set = 1; gie_clr = 1; tick();
        chk("R7 clear wins", int'(irq), 0);
        gie_set = 1; tick();
        chk("R7 set enable", int'(irq), 1);

        for (int i = 0; i < 4000; i++) begin
            tmr_n     = ($urandom % 5) != 0;
            ext_n     = ($urandom % 5) != 0;
            if ($urandom % 4 == 0) port_in = PW'($urandom);
            port_rd   = ($urandom % 6) == 0;
            flag_wr   = ($urandom % 6) == 0;
            mask_wr   = ($urandom % 10) == 0;
            wr_data   = 3'($urandom);
            gie_set   = ($urandom % 8) == 0;
            gie_clr   = ($urandom % 20) == 0;
            irq_ack   = irq && (($urandom % 3) == 0);
            sleep_req = ($urandom % 15) == 0;
            @(negedge clk);
        end
        tick();
        finish_run();
    end
endmodule